// File: doc/BRIEF.md
# Paired-Sample Packing FIFO with DMA Threshold Request

This block sits between a 13-bit converter and the system bus. Each incoming conversion result is 13 bits wide. The block holds the first result of a pair in a staging register. When the second result arrives, it joins the two into one 32-bit word, with each result right-aligned in its own 16-bit half. It then writes that word into a 64-word first-in first-out store.

A consumer reads the oldest word on a combinational read port and pops it with a one-cycle read strobe. The block reports a not-empty flag and a 7-bit word count that can reach 64. A flush strobe discards all stored words and any unpaired sample.

For hands-off draining, a request line rises while the DMA enable is set and the word count is at or above a programmable 6-bit threshold. The threshold is meant to be a power of two. With the enable clear, the store is drained by polling only.

Top module: `sample_pack_fifo`

## Requirements
- R1: After reset the word count is 0, not_empty is 0, overflow is 0, dma_req is 0 and rd_data reads 0.
- R2: A packed word carries the earlier sample of the pair in bits 12:0 and the later sample in bits 28:16; bits 15:13 and 31:29 are zero.
- R3: A lone sample creates no word. The count rises by one in the cycle after the clock edge that accepts the second sample of a pair.
- R4: rd_data shows the oldest stored word. A read strobe on a non-empty store removes that word, and words leave in arrival order.
- R5: The count never exceeds 64 and reaches 64 when the store is full; not_empty is 1 whenever the count is non-zero.
- R6: A word completed while the store holds 64 words and no read is strobed is dropped. The stored contents are unchanged, and the overflow flag sets and stays set until a flush.
- R7: A read strobe on an empty store leaves the count at 0, and rd_data reads 0.
- R8: A flush empties the store, clears the overflow flag and discards the staged half-pair, so the next two samples form the next word. A sample presented in the flush cycle is discarded.
- R9: With dma_en at 1 and a non-zero threshold, dma_req is 1 exactly when the count is greater than or equal to the threshold. A threshold of 0 never requests.
- R10: With dma_en at 0, dma_req stays 0 at any count.
- R11: On a full store, a read strobe in the same cycle as a completed pair accepts the new word. The count stays at 64 and overflow stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Conversion result present this cycle |
| smp_data | input | 13 | Conversion result |
| rd_en | input | 1 | Pop the oldest word |
| flush | input | 1 | Discard all words, staging and overflow |
| dma_en | input | 1 | Allow the threshold request |
| dma_thresh | input | 6 | Request threshold in words |
| rd_data | output | 32 | Oldest word, zero when empty |
| not_empty | output | 1 | At least one word stored |
| word_count | output | 7 | Stored words, 0 to 64 |
| overflow | output | 1 | Sticky: a packed word was dropped |
| dma_req | output | 1 | Threshold request |

## Verification
A pointer or count that slips shows up at the ports right after the faulty edge. rd_data presents a different word than the arrival order predicts, or word_count disagrees with the number of completed pairs minus pops, and the bench compares both after every single cycle. A staging bit left set after a flush only appears two samples later, as a word that is misaligned or arrives early. The flush scenario therefore feeds exactly two fresh samples and checks the resulting word. A wrong full decision appears on the 65th word as a count, an overflow flag or a head word that differs from the expected one.

// File: rtl/sample_pack_fifo.sv
module sample_pack_fifo #(
  parameter int SAMPLE_W = 13,
  parameter int DEPTH    = 64,
  parameter int THR_W    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic [SAMPLE_W-1:0]   smp_data,
  input  logic                  rd_en,
  input  logic                  flush,
  input  logic                  dma_en,
  input  logic [THR_W-1:0]      dma_thresh,
  output logic [31:0]           rd_data,
  output logic                  not_empty,
  output logic [$clog2(DEPTH):0] word_count,
  output logic                  overflow,
  output logic                  dma_req
);
  localparam int HALF_W = 16;
  localparam int PAD_W  = HALF_W - SAMPLE_W;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = PTR_W + 1;

  logic [31:0]         mem [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0]    count;
  logic                half_valid;
  logic [SAMPLE_W-1:0] half_data;

  wire full      = (count == CNT_W'(DEPTH));
  wire pair_done = smp_valid && half_valid && !flush;
  wire pop       = rd_en && (count != '0) && !flush;
  wire push      = pair_done && (!full || pop);
  wire [31:0] packed_word = {{PAD_W{1'b0}}, smp_data, {PAD_W{1'b0}}, half_data};

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= packed_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      half_valid <= 1'b0;
      half_data  <= '0;
      overflow   <= 1'b0;
    end else if (flush) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      half_valid <= 1'b0;
      half_data  <= '0;
      overflow   <= 1'b0;
    end else begin
      if (smp_valid) begin
        half_valid <= !half_valid;
        if (!half_valid) half_data <= smp_data;
      end
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (pair_done && !push) overflow <= 1'b1;
    end
  end

  assign word_count = count;
  assign not_empty  = (count != '0);
  assign rd_data    = not_empty ? mem[rd_ptr] : 32'h0;
  assign dma_req    = dma_en && (dma_thresh != '0) && (count >= CNT_W'(dma_thresh));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_count <= CNT_W'(DEPTH));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !not_empty && !smp_valid && !flush) |=> (word_count == '0 && rd_data == 32'h0));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (word_count == '0 && !overflow && !half_valid));

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush) |=> overflow);

  // R11
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rd_en && pair_done) |=> (word_count == CNT_W'(DEPTH) && $stable(overflow)));

  // R10
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);
endmodule

// File: tb/tb_sample_pack_fifo.sv
module tb_sample_pack_fifo;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;

  logic        clk = 0, rst_n = 0;
  logic        smp_valid = 0, rd_en = 0, flush = 0, dma_en = 0;
  logic [12:0] smp_data = '0;
  logic [5:0]  dma_thresh = '0;
  logic [31:0] rd_data;
  logic        not_empty, overflow, dma_req;
  logic [6:0]  word_count;

  int vectors = 0, fails = 0;
  logic [31:0] model[$];
  bit          m_half_v = 0;
  logic [12:0] m_half = '0;
  bit          m_ovf = 0;

  always #(PERIOD/2) clk = ~clk;

  sample_pack_fifo dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_en(rd_en), .flush(flush), .dma_en(dma_en), .dma_thresh(dma_thresh),
    .rd_data(rd_data), .not_empty(not_empty), .word_count(word_count),
    .overflow(overflow), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [12:0] d, input bit rd, input bit fl);
    smp_valid = v; smp_data = d; rd_en = rd; flush = fl;
    @(posedge clk); #1;
    smp_valid = 0; rd_en = 0; flush = 0;
    if (fl) begin
      model.delete(); m_half_v = 0; m_ovf = 0;
    end else begin
      if (rd && model.size() > 0) void'(model.pop_front());
      if (v) begin
        if (m_half_v) begin
          if (model.size() < DEPTH) model.push_back({3'b0, d, 3'b0, m_half});
          else m_ovf = 1;
          m_half_v = 0;
        end else begin
          m_half = d; m_half_v = 1;
        end
      end
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " count R5"}, 32'(word_count), 32'(model.size()));
    chk({tag, " not_empty R5"}, 32'(not_empty), 32'(model.size() != 0));
    chk({tag, " overflow R6"}, 32'(overflow), 32'(m_ovf));
    chk({tag, " head R4"}, rd_data, model.size() != 0 ? model[0] : 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 count", 32'(word_count), 0);
    chk("R1 not_empty", 32'(not_empty), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_pack;
    step(1, 13'h1FFF, 0, 0);
    chk("R3 lone sample count", 32'(word_count), 0);
    step(1, 13'h0001, 0, 0);
    chk("R3 pair count", 32'(word_count), 1);
    chk("R2 packed word", rd_data, 32'h0001_1FFF);
    step(0, 0, 1, 0);
    chk("R4 pop to empty", 32'(word_count), 0);
  endtask

  task automatic t_order;
    for (int i = 0; i < 6; i++) begin
      step(1, 13'(i * 13'h155 + 7), 0, 0);
      chk_state("order fill");
    end
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1, 0);
      chk_state("order drain R4");
    end
  endtask

  task automatic t_empty_read;
    step(0, 0, 1, 0);
    chk("R7 count", 32'(word_count), 0);
    chk("R7 rd_data", rd_data, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 2 * DEPTH; i++) step(1, 13'(i * 37), 0, 0);
    chk("R5 full count", 32'(word_count), DEPTH);
    chk_state("full");
    step(1, 13'h0AAA, 0, 0);
    step(1, 13'h0555, 1, 0);
    chk("R11 swap count", 32'(word_count), DEPTH);
    chk("R11 no overflow", 32'(overflow), 0);
    chk_state("swap R11");
    step(1, 13'h0123, 0, 0);
    step(1, 13'h0456, 0, 0);
    chk("R6 overflow set", 32'(overflow), 1);
    chk_state("dropped R6");
    step(0, 0, 0, 0);
    chk("R6 overflow sticky", 32'(overflow), 1);
    while (model.size() > 0) begin
      step(0, 0, 1, 0);
      chk_state("drain R4");
    end
  endtask

  task automatic t_flush;
    step(1, 13'h0011, 0, 0);
    step(1, 13'h0022, 0, 0);
    step(1, 13'h0033, 0, 0);
    step(1, 13'h0044, 0, 1);
    chk("R8 flush count", 32'(word_count), 0);
    chk("R8 flush overflow", 32'(overflow), 0);
    step(1, 13'h0101, 0, 0);
    chk("R8 staging cleared", 32'(word_count), 0);
    step(1, 13'h0202, 0, 0);
    chk("R8 fresh word", rd_data, 32'h0202_0101);
    step(0, 0, 0, 1);
    chk_state("flush2 R8");
  endtask

  task automatic t_dma;
    dma_en = 1; dma_thresh = 6'd4;
    for (int i = 0; i < 3; i++) step(1, 13'(i), 0, 0);
    for (int i = 0; i < 3; i++) step(1, 13'(i), 0, 0);
    chk("R9 below threshold", 32'(dma_req), 0);
    step(1, 1, 0, 0); step(1, 2, 0, 0);
    chk("R9 at threshold", 32'(dma_req), 1);
    step(1, 3, 0, 0); step(1, 4, 0, 0);
    chk("R9 above threshold", 32'(dma_req), 1);
    dma_en = 0; #1;
    chk("R10 disabled", 32'(dma_req), 0);
    dma_en = 1; dma_thresh = 6'd0; #1;
    chk("R9 zero threshold", 32'(dma_req), 0);
    dma_thresh = 6'd4;
    step(0, 0, 1, 0);
    chk("R9 back to threshold", 32'(dma_req), 1);
    step(0, 0, 1, 0);
    chk("R9 below after pop", 32'(dma_req), 0);
    dma_en = 0;
    step(0, 0, 0, 1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1;
    @(posedge clk); #1;
    t_reset;
    t_pack;
    t_order;
    step(0, 0, 0, 1);
    t_empty_read;
    t_full;
    t_flush;
    t_dma;
    finish_run;
  end

  initial begin
    #(PERIOD * 100000);
    vectors++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule